// File: doc/BRIEF.md
# Trim-Calibrated Temperature Classifier

This block turns a raw 8-bit thermal sensor code into a calibrated temperature in degrees and grades that reading against a set of configured limits. A per-die trim word is loaded once with a strobe. The block checks that the trim is plausible and falls back to a built-in default when it is not. From the stored trim it also derives the raw sensor codes that correspond to the warning, software-trip and hardware-trip temperatures, so that threshold comparators elsewhere can be programmed directly.

After reset the block is uninitialised and ignores readings. A trim load makes it operational. Each accepted reading yields a registered temperature and a two-bit status one cycle later. A reading that falls outside every band is reported as invalid. The block then returns to the uninitialised state until the trim is loaded again. A typical configuration uses a minimum of 25, a warning at 95, a software trip at 105, a hardware trip at 110 and a maximum of 125.

Top module: `thermal_grade`

## Requirements
- R1: A reading accepted with `raw_valid` appears on `temp_out` one clock later, with `out_valid` high for exactly that one cycle. The value is raw − trim + 25, computed as 10-bit signed.
- R2: On `trim_load`, the stored trim is `trim_word[7:0]` when that value is within 40..100 and `trim_word[15:8]` is zero. Otherwise the stored trim is the default 55.
- R3: A raw code of 0 is reported as temperature 0 without calibration.
- R4: `thr_warn`, `thr_trip` and `thr_hwtrip` each equal their limit + stored trim − 25, as 10-bit unsigned values. They follow the stored trim and the limit inputs combinationally.
- R5: Status codes are normal=0, warning=1, tripped=2 and invalid=3. Status is tripped (2) when `lim_trip` ≤ temperature ≤ `lim_max`.
- R6: Otherwise status is warning (1) when temperature ≥ `lim_warn`. This includes readings above `lim_max`.
- R7: Otherwise status is normal (0) when temperature ≥ `lim_min`, and invalid (3) in all remaining cases, including negative temperatures.
- R8: After an invalid report the block is uninitialised. Further `raw_valid` strobes produce no `out_valid`, and `temp_out` and `status` hold their values until the next `trim_load`.
- R9: After reset the block is uninitialised, the stored trim is 55, `out_valid` is 0, `temp_out` is 0 and `status` is 0. Readings are ignored until a trim load.
- R10: When `trim_load` and `raw_valid` arrive in the same cycle, the reading is graded with the previously stored trim, and the block is operational afterwards even if that reading was invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trim_word | input | 16 | Trim value (low byte) and check field (high byte) |
| trim_load | input | 1 | Strobe that stores the validated trim and enables the block |
| lim_min | input | 8 | Lowest valid temperature |
| lim_warn | input | 8 | Warning limit |
| lim_trip | input | 8 | Software trip limit |
| lim_hwtrip | input | 8 | Hardware trip limit (threshold code only) |
| lim_max | input | 8 | Highest temperature graded as tripped |
| raw_code | input | 8 | Raw sensor code |
| raw_valid | input | 1 | Strobe qualifying `raw_code` |
| temp_out | output | 10 | Calibrated temperature, signed |
| status | output | 2 | Grade of the last reading |
| out_valid | output | 1 | One-cycle pulse with each graded reading |
| thr_warn | output | 10 | Raw code matching the warning limit |
| thr_trip | output | 10 | Raw code matching the software trip limit |
| thr_hwtrip | output | 10 | Raw code matching the hardware trip limit |

## Verification
The in-line properties run on every cycle. They check that the stored trim always stays inside its window, that a trim load always leaves the block operational, that an uninitialised block never raises `out_valid`, that an invalid grade without a reload drops the block out of operation, that a tripped report never lies below its trip limit, and that every threshold code sits above its limit. The exact arithmetic, the band edges, readings above the maximum, the zero-code bypass, the default-trim substitution and the same-cycle load-and-read ordering are only visible through the bench. Its scenarios and its cycle-by-cycle reference model show these against concrete numbers.

// File: rtl/thermal_grade_pkg.sv
package thermal_grade_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_WARN    = 2'd1,
    ST_TRIP    = 2'd2,
    ST_INVALID = 2'd3
  } grade_e;
endpackage

// File: rtl/thermal_grade_trim.sv
module thermal_grade_trim #(
  parameter int CODE_W   = 8,
  parameter int TRIM_LO  = 40,
  parameter int TRIM_HI  = 100,
  parameter int TRIM_DEF = 55
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*CODE_W-1:0]   trim_word,
  input  logic                  trim_load,
  input  logic                  drop_req,
  output logic [CODE_W-1:0]     trim_q,
  output logic                  ready
);
  localparam logic [CODE_W-1:0] LO  = CODE_W'(TRIM_LO);
  localparam logic [CODE_W-1:0] HI  = CODE_W'(TRIM_HI);
  localparam logic [CODE_W-1:0] DEF = CODE_W'(TRIM_DEF);

  function automatic logic [CODE_W-1:0] pick_trim(input logic [2*CODE_W-1:0] w);
    logic [CODE_W-1:0] v;
    logic [CODE_W-1:0] chk;
    v   = w[CODE_W-1:0];
    chk = w[2*CODE_W-1:CODE_W];
    if (v < LO || v > HI || chk != '0) return DEF;
    return v;
  endfunction

  logic [CODE_W-1:0] trim_pick;
  assign trim_pick = pick_trim(trim_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trim_q <= DEF;
      ready  <= 1'b0;
    end else begin
      if (trim_load) begin
        trim_q <= trim_pick;
        ready  <= 1'b1;
      end else if (drop_req) begin
        ready  <= 1'b0;
      end
    end
  end

  p_trim_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_q >= LO) && (trim_q <= HI));

  p_load_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trim_load |=> ready);
endmodule

// File: rtl/thermal_grade_calc.sv
module thermal_grade_calc
  import thermal_grade_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TEMP_W = 10,
  parameter int OFFSET = 25
) (
  input  logic [CODE_W-1:0]        raw,
  input  logic [CODE_W-1:0]        trim,
  input  logic [CODE_W-1:0]        lo_lim,
  input  logic [CODE_W-1:0]        warn_lim,
  input  logic [CODE_W-1:0]        trip_lim,
  input  logic [CODE_W-1:0]        hi_lim,
  output logic signed [TEMP_W-1:0] temp,
  output grade_e                   grade
);
  localparam logic signed [TEMP_W-1:0] OFS = TEMP_W'(OFFSET);

  function automatic logic signed [TEMP_W-1:0] widen(input logic [CODE_W-1:0] v);
    return $signed({{(TEMP_W-CODE_W){1'b0}}, v});
  endfunction

  function automatic logic signed [TEMP_W-1:0] calibrate(
    input logic [CODE_W-1:0] r, input logic [CODE_W-1:0] t);
    if (r == '0) return '0;
    return widen(r) - widen(t) + OFS;
  endfunction

  function automatic grade_e classify(input logic signed [TEMP_W-1:0] v);
    if (v >= widen(trip_lim) && v <= widen(hi_lim)) return ST_TRIP;
    if (v >= widen(warn_lim))                       return ST_WARN;
    if (v >= widen(lo_lim))                         return ST_NORMAL;
    return ST_INVALID;
  endfunction

  assign temp  = calibrate(raw, trim);
  assign grade = classify(temp);
endmodule

// File: rtl/thermal_grade_thresh.sv
module thermal_grade_thresh #(
  parameter int CODE_W  = 8,
  parameter int TEMP_W  = 10,
  parameter int OFFSET  = 25,
  parameter int NUM_LIM = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LIM*CODE_W-1:0]  lim_vec,
  input  logic [CODE_W-1:0]          trim,
  output logic [NUM_LIM*TEMP_W-1:0]  thr_vec
);
  localparam logic [TEMP_W-1:0] OFS = TEMP_W'(OFFSET);

  function automatic logic [TEMP_W-1:0] code_of(
    input logic [CODE_W-1:0] lim, input logic [CODE_W-1:0] t);
    return TEMP_W'(lim) + TEMP_W'(t) - OFS;
  endfunction

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    logic [CODE_W-1:0] lim_g;
    logic [TEMP_W-1:0] thr_g;
    assign lim_g = lim_vec[g*CODE_W +: CODE_W];
    assign thr_g = code_of(lim_g, trim);
    assign thr_vec[g*TEMP_W +: TEMP_W] = thr_g;

    p_thr_above_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      thr_g > TEMP_W'(lim_g));
  end
endmodule

// File: rtl/thermal_grade.sv
module thermal_grade
  import thermal_grade_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int TEMP_W   = 10,
  parameter int OFFSET   = 25,
  parameter int TRIM_LO  = 40,
  parameter int TRIM_HI  = 100,
  parameter int TRIM_DEF = 55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*CODE_W-1:0] trim_word,
  input  logic                trim_load,
  input  logic [CODE_W-1:0]   lim_min,
  input  logic [CODE_W-1:0]   lim_warn,
  input  logic [CODE_W-1:0]   lim_trip,
  input  logic [CODE_W-1:0]   lim_hwtrip,
  input  logic [CODE_W-1:0]   lim_max,
  input  logic [CODE_W-1:0]   raw_code,
  input  logic                raw_valid,
  output logic [TEMP_W-1:0]   temp_out,
  output logic [1:0]          status,
  output logic                out_valid,
  output logic [TEMP_W-1:0]   thr_warn,
  output logic [TEMP_W-1:0]   thr_trip,
  output logic [TEMP_W-1:0]   thr_hwtrip
);
  localparam int NUM_LIM = 3;

  logic [CODE_W-1:0]        trim_q;
  logic                     ready;
  logic                     accept;
  logic                     drop_req;
  logic signed [TEMP_W-1:0] temp_c;
  grade_e                   grade_c;
  logic [NUM_LIM*TEMP_W-1:0] thr_vec;

  assign accept   = ready && raw_valid;
  assign drop_req = accept && (grade_c == ST_INVALID);

  thermal_grade_trim #(
    .CODE_W(CODE_W), .TRIM_LO(TRIM_LO), .TRIM_HI(TRIM_HI), .TRIM_DEF(TRIM_DEF)
  ) u_trim (
    .clk(clk), .rst_n(rst_n), .trim_word(trim_word), .trim_load(trim_load),
    .drop_req(drop_req), .trim_q(trim_q), .ready(ready)
  );

  thermal_grade_calc #(
    .CODE_W(CODE_W), .TEMP_W(TEMP_W), .OFFSET(OFFSET)
  ) u_calc (
    .raw(raw_code), .trim(trim_q), .lo_lim(lim_min), .warn_lim(lim_warn),
    .trip_lim(lim_trip), .hi_lim(lim_max), .temp(temp_c), .grade(grade_c)
  );

  thermal_grade_thresh #(
    .CODE_W(CODE_W), .TEMP_W(TEMP_W), .OFFSET(OFFSET), .NUM_LIM(NUM_LIM)
  ) u_thresh (
    .clk(clk), .rst_n(rst_n), .lim_vec({lim_hwtrip, lim_trip, lim_warn}),
    .trim(trim_q), .thr_vec(thr_vec)
  );

  assign thr_warn   = thr_vec[0*TEMP_W +: TEMP_W];
  assign thr_trip   = thr_vec[1*TEMP_W +: TEMP_W];
  assign thr_hwtrip = thr_vec[2*TEMP_W +: TEMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_out  <= '0;
      status    <= ST_NORMAL;
      out_valid <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        temp_out <= temp_c;
        status   <= grade_c;
      end
    end
  end

  p_uninit_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !out_valid);

  p_invalid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grade_c == ST_INVALID && !trim_load) |=> !ready);

  p_trip_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status == ST_TRIP) |->
      $signed(temp_out) >= $signed({{(TEMP_W-CODE_W){1'b0}}, $past(lim_trip)}));
endmodule

// File: tb/thermal_grade_bench.sv
`timescale 1ns/1ps
module thermal_grade_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trim_word = '0;
  logic        trim_load = 1'b0;
  logic [7:0]  lim_min = 8'd25, lim_warn = 8'd95, lim_trip = 8'd105;
  logic [7:0]  lim_hwtrip = 8'd110, lim_max = 8'd125;
  logic [7:0]  raw_code = '0;
  logic        raw_valid = 1'b0;
  logic [9:0]  temp_out;
  logic [1:0]  status;
  logic        out_valid;
  logic [9:0]  thr_warn, thr_trip, thr_hwtrip;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_grade u_thermal_grade (
    .clk(clk), .rst_n(rst_n), .trim_word(trim_word), .trim_load(trim_load),
    .lim_min(lim_min), .lim_warn(lim_warn), .lim_trip(lim_trip),
    .lim_hwtrip(lim_hwtrip), .lim_max(lim_max), .raw_code(raw_code),
    .raw_valid(raw_valid), .temp_out(temp_out), .status(status),
    .out_valid(out_valid), .thr_warn(thr_warn), .thr_trip(thr_trip),
    .thr_hwtrip(thr_hwtrip)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int  m_trim = 55;
  bit  m_ready = 0;
  bit  e_valid = 0;
  int  e_temp = 0;
  int  e_stat = 0;

  function automatic int ref_trim(input logic [15:0] w);
    int lo;
    lo = int'(w[7:0]);
    if (w[15:8] == 8'd0 && lo >= 40 && lo <= 100) return lo;
    return 55;
  endfunction

  function automatic int ref_grade(input int t);
    if (t >= int'(lim_trip) && t <= int'(lim_max)) return 2;
    if (t >= int'(lim_warn)) return 1;
    if (t >= int'(lim_min)) return 0;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_trim = 55; m_ready = 0; e_valid = 0; e_temp = 0; e_stat = 0;
    end else begin
      bit nxt_ready;
      nxt_ready = m_ready;
      e_valid = 0;
      if (m_ready && raw_valid) begin
        e_temp  = (raw_code == 0) ? 0 : int'(raw_code) - m_trim + 25;
        e_stat  = ref_grade(e_temp);
        e_valid = 1;
        if (e_stat == 3) nxt_ready = 0;
      end
      if (trim_load) begin
        m_trim = ref_trim(trim_word);
        nxt_ready = 1;
      end
      m_ready = nxt_ready;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 out_valid pulse", int'(out_valid), int'(e_valid));
      chk("R1 temp_out", int'($signed(temp_out)), e_temp);
      chk("R5 status", int'(status), e_stat);
      chk("R4 thr_warn", int'(thr_warn), int'(lim_warn) + m_trim - 25);
      chk("R4 thr_trip", int'(thr_trip), int'(lim_trip) + m_trim - 25);
      chk("R4 thr_hwtrip", int'(thr_hwtrip), int'(lim_hwtrip) + m_trim - 25);
    end
  end

  task automatic load(input logic [15:0] w);
    @(negedge clk); #1 trim_load = 1'b1; trim_word = w;
    @(negedge clk); #1 trim_load = 1'b0;
  endtask

  task automatic rd(input int r, input int et, input int es, input string tag);
    @(negedge clk); #1 raw_valid = 1'b1; raw_code = 8'(r);
    @(negedge clk);
    chk(tag, int'(out_valid), 1);
    chk(tag, int'($signed(temp_out)), et);
    chk(tag, int'(status), es);
    #1 raw_valid = 1'b0;
  endtask

  task automatic rd_ignored(input int r, input int hold_t, input int hold_s, input string tag);
    @(negedge clk); #1 raw_valid = 1'b1; raw_code = 8'(r);
    @(negedge clk);
    chk(tag, int'(out_valid), 0);
    chk(tag, int'($signed(temp_out)), hold_t);
    chk(tag, int'(status), hold_s);
    #1 raw_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset temp", int'(temp_out), 0);
    chk("R9 reset status", int'(status), 0);
    chk("R9 reset trim default", int'(thr_warn), 125);
    rd_ignored(120, 0, 0, "R9 reading before trim load");

    load(16'h0032);
    chk("R2 trim 50 accepted", int'(thr_warn), 120);
    rd(120, 95, 1, "R6 warning at limit");
    rd(130, 105, 2, "R5 trip at limit");
    rd(150, 125, 2, "R5 trip at max");
    rd(151, 126, 1, "R6 above max is warning");
    rd(119, 94, 0, "R7 normal below warning");
    rd(50, 25, 0, "R7 normal at minimum");
    rd(49, 24, 3, "R7 invalid below minimum");
    rd_ignored(120, 24, 3, "R8 ignored after invalid");

    load(16'h0064);
    chk("R2 trim 100 accepted", int'(thr_hwtrip), 185);
    load(16'h0027);
    chk("R2 trim 39 replaced", int'(thr_warn), 125);
    load(16'h0064);
    load(16'h0065);
    chk("R2 trim 101 replaced", int'(thr_warn), 125);
    load(16'h0164);
    chk("R2 high field nonzero replaced", int'(thr_warn), 125);
    load(16'h0028);
    chk("R2 trim 40 accepted", int'(thr_warn), 110);
    rd(0, 0, 3, "R3 zero code bypass");
    load(16'h0064);
    rd(10, -65, 3, "R7 negative is invalid");

    load(16'h0064);
    @(negedge clk); #1 trim_load = 1'b1; trim_word = 16'h0028;
    raw_valid = 1'b1; raw_code = 8'd200;
    @(negedge clk);
    chk("R10 old trim used", int'($signed(temp_out)), 125);
    chk("R10 old trim status", int'(status), 2);
    chk("R10 new trim stored", int'(thr_warn), 110);
    #1 trim_load = 1'b0; raw_valid = 1'b0;
    rd(200, 185, 1, "R10 new trim in use");
    @(negedge clk); #1 trim_load = 1'b1; trim_word = 16'h0032;
    raw_valid = 1'b1; raw_code = 8'd5;
    @(negedge clk);
    chk("R10 invalid with load", int'(status), 3);
    #1 trim_load = 1'b0; raw_valid = 1'b0;
    rd(120, 95, 1, "R10 stays operational");

    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      raw_valid = ($urandom_range(0, 3) != 0);
      raw_code  = 8'($urandom_range(0, 255));
      trim_load = ($urandom_range(0, 9) == 0);
      trim_word = {($urandom_range(0, 5) == 0) ? 8'($urandom_range(1, 255)) : 8'd0,
                   8'($urandom_range(30, 110))};
      if (i % 150 == 75) begin
        lim_warn = 8'($urandom_range(60, 100));
        lim_trip = 8'($urandom_range(90, 120));
        lim_max  = 8'($urandom_range(110, 140));
      end
    end
    @(negedge clk); #1 raw_valid = 1'b0; trim_load = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule